// File: doc/BRIEF.md
# Single-Wire Slave Bit Engine

This block is the bit-level front end of a slave device on a single-wire, open-drain, half-duplex bus. The bus idles high, and the master starts every reset and every bit slot by pulling the line low. The block runs on a fast system clock and samples the bus through a two-flop synchronizer. It drives a single pull-down enable that an open-drain pad turns into a low level on the wire. It recognises reset pulses by their length and answers each one with a presence pulse. It turns master write slots into received bits. In read slots it drives a bit that the upper layer supplies. Bits travel least significant first, one per slot. Ordering the bits into bytes is left to the upper layer.

There are two timing sets, standard and overdrive. The upper layer selects overdrive with a one-clock strobe after it has decoded a speed-raising command. Only a reset pulse that is long enough returns the block to standard speed. After every rising edge the input passes through a hold-off filter, which hides short low glitches that follow the edge. Every duration is a parameter counted in clock cycles, so one netlist serves any system clock.

Top module: `sw_bit_engine`

## Requirements
- R1: After the asynchronous reset is released with the bus idle high, bus_pull is 0, od_mode is 0, and reset_detected, rx_bit_valid and tx_request stay 0.
- R2: In standard mode, a bus low time of at least RST_STD_CYC clock cycles is a reset. reset_detected is then high for exactly one clock, and a low time of RST_STD_CYC-1 cycles is handled as a bit slot instead.
- R3: After a detected reset, bus_pull rises on the (PDH+4)-th rising clock edge after the first edge that samples the bus high again, and it stays high for exactly PDL cycles. PDH and PDL belong to the speed that is in force after the reset.
- R4: With tx_active low, each slot produces exactly one rx_bit_valid pulse. rx_bit is 0 when the master held the line low for at least SAMP+2 cycles, and 1 when it held the line low for SAMP+1 cycles or fewer. A reset pulse also yields a 0 sample, which the upper layer discards.
- R5: With tx_active high, tx_request pulses once at the start of the slot. If tx_bit is 0, bus_pull is high for exactly RD0 cycles. If tx_bit is 1, bus_pull stays low. No rx_bit_valid is produced in a read slot.
- R6: A one-clock od_set strobe sets od_mode, and from then on the overdrive timing set applies.
- R7: In overdrive, a low time from RST_OD_CYC up to and including OD_KEEP_CYC cycles is a reset that leaves od_mode at 1.
- R8: In overdrive, a reset longer than OD_KEEP_CYC cycles clears od_mode, and the presence pulse then uses standard timing. od_mode never falls without reset_detected in the same cycle.
- R9: For REH cycles after the filtered line rises, low input levels are ignored, so a short glitch in that window starts no slot.
- R10: In overdrive, a low time of RST_OD_CYC-1 cycles is a slot and decodes as a 0, not a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Raw bus level, 1 = high |
| bus_pull | output | 1 | Enable for the open-drain pull-down |
| od_set | input | 1 | One-clock strobe that selects overdrive timing |
| od_mode | output | 1 | Current speed, 1 = overdrive |
| reset_detected | output | 1 | One-clock pulse at the end of a valid reset |
| rx_bit_valid | output | 1 | One-clock pulse when a write-slot bit is sampled |
| rx_bit | output | 1 | Received bit value |
| tx_active | input | 1 | Treat the following slots as read slots |
| tx_bit | input | 1 | Bit to return in a read slot |
| tx_request | output | 1 | Pulse at read-slot start, the cycle in which tx_bit is taken |

## Verification
The hardest case to reach is a glitch that arrives after the controller has gone back to idle but while the hold-off window is still open. The master cannot easily place an edge there, because the window starts from a rise the slave itself caused. The stimulus waits for the presence pull-down to drop, counts three clocks so that the filtered line has risen, and then drives a two-clock low pulse, which must not start a slot. Reset-length boundaries are directed at exact counts on both sides of each threshold in both speeds. Random read and write slots, with speed changes between them, cover the rest.

// File: rtl/sw_bit_pkg.sv
package sw_bit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_PRES_HI,
    ST_PRES_LO,
    ST_SETTLE
  } bit_state_e;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  // idle bus level is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sw_holdoff.sv
module sw_holdoff #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s,
  input  logic [CW-1:0] reh_cyc,
  output logic          line_f
);
  logic          lf_q, lf_d;
  logic [CW-1:0] hold_q, hold_d;

  always_comb begin
    lf_d   = lf_q;
    hold_d = hold_q;
    if (!lf_q && line_s) begin
      lf_d   = 1'b1;
      hold_d = reh_cyc;
    end else if (hold_q != '0) begin
      hold_d = hold_q - 1'b1;
    end else begin
      lf_d = line_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_q   <= 1'b1;
      hold_q <= '0;
    end else begin
      lf_q   <= lf_d;
      hold_q <= hold_d;
    end
  end

  assign line_f = lf_q;

  AST_HOLD_MASKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) |=> line_f) else $error("hold-off window let a low through"); // R9
endmodule

// File: rtl/sw_slot_ctrl.sv
module sw_slot_ctrl
  import sw_bit_pkg::*;
#(
  parameter int CW          = 16,
  parameter int RST_STD_CYC = 48000,
  parameter int RST_OD_CYC  = 4800,
  parameter int OD_KEEP_CYC = 8000,
  parameter int PDH_STD_CYC = 3000,
  parameter int PDL_STD_CYC = 12000,
  parameter int PDH_OD_CYC  = 300,
  parameter int PDL_OD_CYC  = 1200,
  parameter int SAMP_STD_CYC = 3000,
  parameter int SAMP_OD_CYC  = 400,
  parameter int RD0_STD_CYC  = 3000,
  parameter int RD0_OD_CYC   = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_f,
  input  logic od_set,
  input  logic tx_active,
  input  logic tx_bit,
  output logic bus_pull,
  output logic od_mode,
  output logic reset_detected,
  output logic rx_bit_valid,
  output logic rx_bit,
  output logic tx_request
);
  localparam logic [CW-1:0] RSTM1_S = CW'(RST_STD_CYC - 1);
  localparam logic [CW-1:0] RSTM1_O = CW'(RST_OD_CYC - 1);
  localparam logic [CW-1:0] KEEP_C  = CW'(OD_KEEP_CYC);
  localparam logic [CW-1:0] PDHM1_S = CW'(PDH_STD_CYC - 1);
  localparam logic [CW-1:0] PDHM1_O = CW'(PDH_OD_CYC - 1);
  localparam logic [CW-1:0] PDLM1_S = CW'(PDL_STD_CYC - 1);
  localparam logic [CW-1:0] PDLM1_O = CW'(PDL_OD_CYC - 1);
  localparam logic [CW-1:0] SAMP_S  = CW'(SAMP_STD_CYC);
  localparam logic [CW-1:0] SAMP_O  = CW'(SAMP_OD_CYC);
  localparam logic [CW-1:0] RD0_S   = CW'(RD0_STD_CYC);
  localparam logic [CW-1:0] RD0_O   = CW'(RD0_OD_CYC);

  bit_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          od_q, od_d;
  logic          rd_q, rd_d;
  logic          drv_q, drv_d;
  logic          rdet_q, rdet_d;
  logic          rxv_q, rxv_d;
  logic          rxb_q, rxb_d;

  // timing set picked by the speed flag
  logic [CW-1:0] rst_m1, pdh_m1, pdl_m1, samp, rd0;
  assign rst_m1 = od_q ? RSTM1_O : RSTM1_S;
  assign pdh_m1 = od_q ? PDHM1_O : PDHM1_S;
  assign pdl_m1 = od_q ? PDLM1_O : PDLM1_S;
  assign samp   = od_q ? SAMP_O  : SAMP_S;
  assign rd0    = od_q ? RD0_O   : RD0_S;

  always_comb begin
    st_d       = st_q;
    cnt_d      = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
    od_d       = od_q | od_set;
    rd_d       = rd_q;
    drv_d      = drv_q;
    rdet_d     = 1'b0;
    rxv_d      = 1'b0;
    rxb_d      = rxb_q;
    tx_request = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (!line_f) begin
          st_d       = ST_SLOT;
          rd_d       = tx_active;
          drv_d      = tx_active & ~tx_bit;
          tx_request = tx_active;
        end
      end
      ST_SLOT: begin
        if (cnt_q == samp && !rd_q) begin
          rxv_d = 1'b1;
          rxb_d = line_f;
        end
        if (line_f && cnt_q > samp) begin
          if (cnt_q >= rst_m1) begin
            st_d   = ST_PRES_HI;
            cnt_d  = '0;
            rdet_d = 1'b1;
            od_d   = od_q & (cnt_q < KEEP_C);
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_PRES_HI: begin
        if (cnt_q == pdh_m1) begin
          st_d  = ST_PRES_LO;
          cnt_d = '0;
        end
      end
      ST_PRES_LO: begin
        if (cnt_q == pdl_m1) begin
          st_d  = ST_SETTLE;
          cnt_d = '0;
        end
      end
      ST_SETTLE: begin
        if (line_f) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      od_q   <= 1'b0;
      rd_q   <= 1'b0;
      drv_q  <= 1'b0;
      rdet_q <= 1'b0;
      rxv_q  <= 1'b0;
      rxb_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      od_q   <= od_d;
      rd_q   <= rd_d;
      drv_q  <= drv_d;
      rdet_q <= rdet_d;
      rxv_q  <= rxv_d;
      rxb_q  <= rxb_d;
    end
  end

  assign bus_pull       = (st_q == ST_PRES_LO) || (st_q == ST_SLOT && drv_q && cnt_q < rd0);
  assign od_mode        = od_q;
  assign reset_detected = rdet_q;
  assign rx_bit_valid   = rxv_q;
  assign rx_bit         = rxb_q;

  AST_RST_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    reset_detected |=> !reset_detected) else $error("reset pulse too long"); // R2
  AST_PRES_FOLLOWS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    reset_detected |-> (st_q == ST_PRES_HI && !bus_pull)) else $error("no presence wait"); // R3
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_bit_valid, reset_detected, tx_request})) else $error("events overlap"); // R4
  AST_NO_RX_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_valid |-> !rd_q) else $error("rx reported in read slot"); // R5
  AST_OD_FALL_NEEDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od_mode) |-> reset_detected) else $error("speed dropped without reset"); // R8
endmodule

// File: rtl/sw_bit_engine.sv
module sw_bit_engine #(
  parameter int RST_STD_CYC  = 48000,
  parameter int RST_OD_CYC   = 4800,
  parameter int OD_KEEP_CYC  = 8000,
  parameter int PDH_STD_CYC  = 3000,
  parameter int PDL_STD_CYC  = 12000,
  parameter int PDH_OD_CYC   = 300,
  parameter int PDL_OD_CYC   = 1200,
  parameter int SAMP_STD_CYC = 3000,
  parameter int SAMP_OD_CYC  = 400,
  parameter int RD0_STD_CYC  = 3000,
  parameter int RD0_OD_CYC   = 400,
  parameter int REH_STD_CYC  = 300,
  parameter int REH_OD_CYC   = 100,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic bus_pull,
  input  logic od_set,
  output logic od_mode,
  output logic reset_detected,
  output logic rx_bit_valid,
  output logic rx_bit,
  input  logic tx_active,
  input  logic tx_bit,
  output logic tx_request
);
  // a sum of all durations bounds the largest one
  localparam int SPAN = RST_STD_CYC + RST_OD_CYC + OD_KEEP_CYC + PDH_STD_CYC + PDL_STD_CYC
                      + PDH_OD_CYC + PDL_OD_CYC + SAMP_STD_CYC + SAMP_OD_CYC + RD0_STD_CYC
                      + RD0_OD_CYC + REH_STD_CYC + REH_OD_CYC + 2;
  localparam int CW = $clog2(SPAN) + 1;

  logic          line_s, line_f;
  logic [CW-1:0] reh_cyc;

  assign reh_cyc = od_mode ? CW'(REH_OD_CYC) : CW'(REH_STD_CYC);

  sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(bus_in), .dout(line_s)
  );

  sw_holdoff #(.CW(CW)) u_holdoff (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .reh_cyc(reh_cyc), .line_f(line_f)
  );

  sw_slot_ctrl #(
    .CW(CW), .RST_STD_CYC(RST_STD_CYC), .RST_OD_CYC(RST_OD_CYC), .OD_KEEP_CYC(OD_KEEP_CYC),
    .PDH_STD_CYC(PDH_STD_CYC), .PDL_STD_CYC(PDL_STD_CYC), .PDH_OD_CYC(PDH_OD_CYC),
    .PDL_OD_CYC(PDL_OD_CYC), .SAMP_STD_CYC(SAMP_STD_CYC), .SAMP_OD_CYC(SAMP_OD_CYC),
    .RD0_STD_CYC(RD0_STD_CYC), .RD0_OD_CYC(RD0_OD_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .line_f(line_f), .od_set(od_set),
    .tx_active(tx_active), .tx_bit(tx_bit), .bus_pull(bus_pull), .od_mode(od_mode),
    .reset_detected(reset_detected), .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit),
    .tx_request(tx_request)
  );
endmodule

// File: tb/tb_sw_bit_engine.sv
module tb_sw_bit_engine;
  localparam int RST_S = 200, RST_O = 40, KEEP = 60;
  localparam int PDH_S = 20, PDL_S = 50, PDH_O = 4, PDL_O = 10;
  localparam int SAMP_S = 25, SAMP_O = 5, RD0_S = 30, RD0_O = 6;
  localparam int REH_S = 6, REH_O = 3;

  logic clk, rst_n, mlow;
  logic bus_in, bus_pull, od_set, od_mode, reset_detected;
  logic rx_bit_valid, rx_bit, tx_active, tx_bit, tx_request;

  int n_chk, n_fail, rx_cnt, rst_cnt, txreq_cnt, pull_cyc;
  logic rx_last;
  bit done;

  assign bus_in = !(mlow | bus_pull);

  sw_bit_engine #(
    .RST_STD_CYC(RST_S), .RST_OD_CYC(RST_O), .OD_KEEP_CYC(KEEP),
    .PDH_STD_CYC(PDH_S), .PDL_STD_CYC(PDL_S), .PDH_OD_CYC(PDH_O), .PDL_OD_CYC(PDL_O),
    .SAMP_STD_CYC(SAMP_S), .SAMP_OD_CYC(SAMP_O), .RD0_STD_CYC(RD0_S), .RD0_OD_CYC(RD0_O),
    .REH_STD_CYC(REH_S), .REH_OD_CYC(REH_O)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_pull(bus_pull), .od_set(od_set),
    .od_mode(od_mode), .reset_detected(reset_detected), .rx_bit_valid(rx_bit_valid),
    .rx_bit(rx_bit), .tx_active(tx_active), .tx_bit(tx_bit), .tx_request(tx_request)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      if (rx_bit_valid) begin rx_cnt++; rx_last = rx_bit; end
      if (reset_detected) rst_cnt++;
      if (tx_request) txreq_cnt++;
      if (bus_pull) pull_cyc++;
    end
  end

  function automatic int f_pdh(bit od); return od ? PDH_O : PDH_S; endfunction
  function automatic int f_pdl(bit od); return od ? PDL_O : PDL_S; endfunction
  function automatic int f_samp(bit od); return od ? SAMP_O : SAMP_S; endfunction
  function automatic int f_slot(bit od); return od ? 22 : 70; endfunction
  function automatic int f_wlow(bit od, bit b); return b ? (od ? 2 : 5) : (od ? 10 : 50); endfunction
  function automatic int f_rdpull(bit od, bit b); return b ? 0 : (od ? RD0_O : RD0_S); endfunction
  function automatic bit f_wbit(bit od, int low); return (low >= f_samp(od) + 2) ? 1'b0 : 1'b1; endfunction

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int low, input bit od_exp, input string tag);
    int rc0, k, pl;
    rc0 = rst_cnt;
    mlow = 1'b1;
    repeat (low) tick();
    mlow = 1'b0;
    k = 0;
    while (!bus_pull && k < 1000) begin tick(); k++; end
    chk(k == 4 + f_pdh(od_exp), {tag, " R3 presence delay"}, k, 4 + f_pdh(od_exp));
    chk(rst_cnt == rc0 + 1, {tag, " R2 reset pulse count"}, rst_cnt - rc0, 1);
    chk(od_mode == od_exp, {tag, " speed after reset R8"}, od_mode, od_exp);
    pl = 0;
    while (bus_pull && pl < 1000) begin tick(); pl++; end
    chk(pl == f_pdl(od_exp), {tag, " R3 presence length"}, pl, f_pdl(od_exp));
  endtask

  task automatic write_low(input int low, input string tag);
    int rc0;
    bit od, exp;
    od = od_mode;
    exp = f_wbit(od, low);
    rc0 = rx_cnt;
    mlow = 1'b1;
    repeat (low) tick();
    mlow = 1'b0;
    repeat (f_slot(od) - low) tick();
    chk(rx_cnt == rc0 + 1, {tag, " R4 one sample per slot"}, rx_cnt - rc0, 1);
    chk(rx_last == exp, {tag, " R4 sampled value"}, rx_last, exp);
  endtask

  task automatic read_bit(input bit b, input string tag);
    int pc0, tr0, rc0;
    bit od;
    od = od_mode;
    pc0 = pull_cyc; tr0 = txreq_cnt; rc0 = rx_cnt;
    tx_active = 1'b1;
    tx_bit = b;
    mlow = 1'b1;
    repeat (4) tick();
    mlow = 1'b0;
    repeat (f_slot(od) - 4) tick();
    tx_active = 1'b0;
    chk(pull_cyc - pc0 == f_rdpull(od, b), {tag, " R5 read pull length"}, pull_cyc - pc0, f_rdpull(od, b));
    chk(txreq_cnt == tr0 + 1, {tag, " R5 tx_request once"}, txreq_cnt - tr0, 1);
    chk(rx_cnt == rc0, {tag, " R5 no rx in read"}, rx_cnt - rc0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int rc0, r;
    bit b;
    n_chk = 0; n_fail = 0; rx_cnt = 0; rst_cnt = 0; txreq_cnt = 0; pull_cyc = 0;
    rx_last = 1'b1; done = 1'b0;
    mlow = 1'b0; od_set = 1'b0; tx_active = 1'b0; tx_bit = 1'b1; rst_n = 1'b0;
    r = $urandom(32'h5A17);
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (10) tick();
    // R1 reset state
    chk(bus_pull == 1'b0, "R1 bus_pull idle", bus_pull, 0);
    chk(od_mode == 1'b0, "R1 od_mode idle", od_mode, 0);
    chk(rst_cnt + rx_cnt + txreq_cnt == 0, "R1 no events", rst_cnt + rx_cnt + txreq_cnt, 0);

    // R2 and R3 standard reset, then R9 glitch right after presence
    do_reset(RST_S, 1'b0, "std reset");
    rc0 = rx_cnt;
    repeat (3) tick();
    mlow = 1'b1;
    repeat (2) tick();
    mlow = 1'b0;
    repeat (40) tick();
    chk(rx_cnt == rc0, "R9 glitch in hold-off ignored", rx_cnt - rc0, 0);
    write_low(f_wlow(1'b0, 1'b1), "after glitch");

    // R2 boundary: one cycle short is a slot
    rc0 = rst_cnt;
    write_low(RST_S - 1, "std short reset");
    chk(rst_cnt == rc0, "R2 short low not a reset", rst_cnt - rc0, 0);
    repeat (20) tick();

    // R4 sample boundary
    write_low(SAMP_S + 1, "std boundary one");
    write_low(SAMP_S + 2, "std boundary zero");
    write_low(f_wlow(1'b0, 1'b0), "std w0");
    read_bit(1'b0, "std read0");
    read_bit(1'b1, "std read1");

    // R6 overdrive
    od_set = 1'b1; tick(); od_set = 1'b0; tick();
    chk(od_mode == 1'b1, "R6 od_set takes effect", od_mode, 1);
    write_low(SAMP_O + 1, "od boundary one");
    write_low(SAMP_O + 2, "od boundary zero");
    read_bit(1'b0, "od read0");

    // R7 short resets keep overdrive, R10 below threshold is a slot
    do_reset(KEEP, 1'b1, "od keep reset R7");
    repeat (10) tick();
    do_reset(RST_O, 1'b1, "od min reset R7");
    repeat (10) tick();
    rc0 = rst_cnt;
    write_low(RST_O - 1, "od short R10");
    chk(rst_cnt == rc0, "R10 below od threshold not a reset", rst_cnt - rc0, 0);
    repeat (10) tick();

    // R8 reset just past the keep limit returns to standard
    do_reset(KEEP + 1, 1'b0, "od clear reset R8");
    repeat (20) tick();

    // constrained random mix
    for (int i = 0; i < 120; i++) begin
      r = $urandom % 10;
      b = 1'(($urandom >> 3) & 1);
      if (r == 0) begin
        if (od_mode) begin
          do_reset(RST_S + 20, 1'b0, "rand long reset R8");
          repeat (20) tick();
        end else begin
          od_set = 1'b1; tick(); od_set = 1'b0; tick();
          chk(od_mode == 1'b1, "rand R6 od_set", od_mode, 1);
        end
      end else if (r < 6) begin
        write_low(f_wlow(od_mode, b), "rand write R4");
      end else begin
        read_bit(b, "rand read R5");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule